// File: doc/BRIEF.md
# Asynchronous Static RAM Controller

This block lets a clocked design read and write an external asynchronous static RAM of 32768 bytes. A client places a request (address, write data and a read/write flag) while `ready` is high. The controller takes it, sequences the active-low chip-select, write-enable and output-enable lines together with the address and data buses, and signals completion with a one-cycle `done` pulse. For a read, the byte is then available on `rd_data`.

All memory timing is given as nanosecond parameters. Each one becomes a whole number of clock cycles through ceiling division by the clock period, with a floor of one cycle. The write pulse covers the longest of three limits: the pulse width, data setup before the pulse ends, and address setup before the pulse ends. The recovery phase covers both the write recovery time and the rest of the minimum write cycle. After every read, the controller waits out the output-float time before it returns to idle. Its own data driver is therefore never enabled while the memory may still be driving the bus.

The state machine has five states. `ST_IDLE` goes to `ST_RD_ACCESS` on a read request or to `ST_WR_PULSE` on a write request. `ST_RD_ACCESS` goes to `ST_RD_FLOAT` when the access wait ends and the byte is captured. `ST_RD_FLOAT` goes to `ST_IDLE` when the float wait ends. `ST_WR_PULSE` goes to `ST_WR_RECOVER` when the pulse wait ends. `ST_WR_RECOVER` goes to `ST_IDLE` when the recovery wait ends. Every wait is a down-counter that is loaded on entry to its state.

Top module: `async_sram_ctrl`

## Requirements
- R1: While reset is held and just after it, `sram_cs_n`, `sram_we_n` and `sram_oe_n` are 1, `sram_dq_oe` is 0, `done` is 0 and `ready` is 1.
- R2: `ready` falls in the cycle after a request is accepted and stays 0 until the controller is idle again. A request raised while `ready` is 0 is ignored and changes no memory byte.
- R3: A read holds `sram_cs_n`=0, `sram_oe_n`=0 and `sram_we_n`=1 for exactly AA_CYC = max(1, ceil(T_AA_NS/CLK_PERIOD_NS)) cycles (3 by default), with `sram_addr` stable while chip select is low.
- R4: A write holds `sram_we_n`=0 with `sram_cs_n`=0 and `sram_oe_n`=1 for exactly WP_CYC cycles, the largest of the ceiling cycle counts of T_WP_NS, T_DW_NS and T_AW_NS (3 by default). Address and data are stable for the whole pulse.
- R5: `sram_dq_oe` is 1 only during the write pulse and write recovery, and never while `sram_oe_n` is 0.
- R6: After the write pulse, `sram_we_n` returns to 1 while chip select, address and data are held for REC_CYC = max(ceil(T_WR_NS/period), WC_CYC-WP_CYC, 1) cycles (1 by default).
- R7: After a read, all three control lines are 1 for HZ_CYC = max(1, ceil(T_OHZ_NS/period)) cycles (2 by default) before `ready` rises. `sram_dq_oe` cannot rise until `sram_oe_n` has been 1 for at least that long.
- R8: `done` is a single-cycle pulse. For a read it rises AA_CYC cycles after acceptance with the byte on `rd_data`, and `rd_data` keeps that byte through later writes until the next read. For a write it rises WP_CYC+REC_CYC cycles after acceptance.
- R9: Control encoding: chip select high forces write enable and output enable high, and write enable low is never combined with output enable low.
- R10: A read returns the byte most recently written to that address, or the memory's prior content if the address was never written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req | input | 1 | Request valid; taken when `ready` is 1 |
| req_wr | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W (15) | Byte address |
| req_wdata | input | DATA_W (8) | Byte to write |
| ready | output | 1 | Controller idle and able to take a request |
| rd_data | output | DATA_W (8) | Byte captured by the last read |
| done | output | 1 | One-cycle completion pulse |
| sram_addr | output | ADDR_W (15) | Memory address bus |
| sram_cs_n | output | 1 | Chip select, active low |
| sram_we_n | output | 1 | Write enable, active low |
| sram_oe_n | output | 1 | Output enable, active low |
| sram_dq_o | output | DATA_W (8) | Byte driven onto the memory data bus |
| sram_dq_oe | output | 1 | Enable of the controller's data-bus driver |
| sram_dq_i | input | DATA_W (8) | Byte sampled from the memory data bus |

## Verification
The hardest situation to reach from the ports is a read followed straight away by a write. In that case the controller's driver must stay off until the memory has released the bus, and memory timing is not visible at a clock edge. The bench runs a time-based memory model. It returns a corrupted byte until the access time has passed since the last address or enable change, records when output enable was released, and measures each write pulse, data setup and address setup in nanoseconds. A long series of mixed reads and writes on a small address window produces many read-to-write turnarounds, each checked against the float deadline, alongside an address sweep and a deliberate request made while the controller is busy.

// File: rtl/sram_ctrl_pkg.sv
`timescale 1ns/1ps
package sram_ctrl_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_RD_ACCESS,
        ST_RD_FLOAT,
        ST_WR_PULSE,
        ST_WR_RECOVER
    } ctrl_state_e;

    // Nanoseconds to whole clock cycles, rounded up, never below one.
    function automatic int ns_to_cyc(input int ns, input int period_ns);
        int c;
        c = (ns + period_ns - 1) / period_ns;
        if (c < 1) c = 1;
        return c;
    endfunction

    function automatic int max2(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/sram_wait_timer.sv
`timescale 1ns/1ps
module sram_wait_timer #(
    parameter int CNT_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic             zero
);
    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= load_val;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign zero = (cnt_q == '0);
endmodule

// File: rtl/sram_io_latch.sv
`timescale 1ns/1ps
module sram_io_latch #(
    parameter int ADDR_W = 15,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              take_req,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    input  logic              take_rd,
    input  logic [DATA_W-1:0] dq_i,
    output logic [ADDR_W-1:0] addr_q,
    output logic [DATA_W-1:0] wdata_q,
    output logic [DATA_W-1:0] rdata_q
);
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_q  <= '0;
            wdata_q <= '0;
        end else if (take_req) begin
            addr_q  <= req_addr;
            wdata_q <= req_wdata;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rdata_q <= '0;
        end else if (take_rd) begin
            rdata_q <= dq_i;
        end
    end
endmodule

// File: rtl/async_sram_ctrl.sv
`timescale 1ns/1ps
module async_sram_ctrl
    import sram_ctrl_pkg::*;
#(
    parameter int ADDR_W        = 15,
    parameter int DATA_W        = 8,
    parameter int CLK_PERIOD_NS = 4,
    parameter int T_AA_NS       = 12,
    parameter int T_OHZ_NS      = 6,
    parameter int T_WP_NS       = 10,
    parameter int T_DW_NS       = 7,
    parameter int T_AW_NS       = 10,
    parameter int T_WR_NS       = 1,
    parameter int T_WC_NS       = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req,
    input  logic              req_wr,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    output logic              ready,
    output logic [DATA_W-1:0] rd_data,
    output logic              done,
    output logic [ADDR_W-1:0] sram_addr,
    output logic              sram_cs_n,
    output logic              sram_we_n,
    output logic              sram_oe_n,
    output logic [DATA_W-1:0] sram_dq_o,
    output logic              sram_dq_oe,
    input  logic [DATA_W-1:0] sram_dq_i
);
    localparam int AA_CYC  = ns_to_cyc(T_AA_NS, CLK_PERIOD_NS);
    localparam int HZ_CYC  = ns_to_cyc(T_OHZ_NS, CLK_PERIOD_NS);
    localparam int WP_CYC  = max2(ns_to_cyc(T_WP_NS, CLK_PERIOD_NS),
                                  max2(ns_to_cyc(T_DW_NS, CLK_PERIOD_NS),
                                       ns_to_cyc(T_AW_NS, CLK_PERIOD_NS)));
    localparam int WC_CYC  = ns_to_cyc(T_WC_NS, CLK_PERIOD_NS);
    localparam int REC_CYC = max2(ns_to_cyc(T_WR_NS, CLK_PERIOD_NS), WC_CYC - WP_CYC);
    localparam int MAX_CYC = max2(max2(AA_CYC, HZ_CYC), max2(WP_CYC, REC_CYC));
    localparam int CNT_W   = $clog2(MAX_CYC + 1);

    ctrl_state_e state_q, state_d;
    logic             tmr_zero;
    logic             tmr_load;
    logic [CNT_W-1:0] tmr_val;
    logic             accept;
    logic             rd_take;
    logic             done_q;

    assign accept  = (state_q == ST_IDLE) && req;
    assign rd_take = (state_q == ST_RD_ACCESS) && tmr_zero;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:       if (req)      state_d = req_wr ? ST_WR_PULSE : ST_RD_ACCESS;
            ST_RD_ACCESS:  if (tmr_zero) state_d = ST_RD_FLOAT;
            ST_RD_FLOAT:   if (tmr_zero) state_d = ST_IDLE;
            ST_WR_PULSE:   if (tmr_zero) state_d = ST_WR_RECOVER;
            ST_WR_RECOVER: if (tmr_zero) state_d = ST_IDLE;
            default:                     state_d = ST_IDLE;
        endcase
    end

    assign tmr_load = (state_d != state_q);

    always_comb begin
        unique case (state_d)
            ST_RD_ACCESS:  tmr_val = CNT_W'(AA_CYC - 1);
            ST_RD_FLOAT:   tmr_val = CNT_W'(HZ_CYC - 1);
            ST_WR_PULSE:   tmr_val = CNT_W'(WP_CYC - 1);
            ST_WR_RECOVER: tmr_val = CNT_W'(REC_CYC - 1);
            default:       tmr_val = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            done_q  <= 1'b0;
        end else begin
            state_q <= state_d;
            done_q  <= tmr_zero && ((state_q == ST_RD_ACCESS) || (state_q == ST_WR_RECOVER));
        end
    end

    always_comb begin
        sram_cs_n  = 1'b1;
        sram_we_n  = 1'b1;
        sram_oe_n  = 1'b1;
        sram_dq_oe = 1'b0;
        unique case (state_q)
            ST_RD_ACCESS: begin
                sram_cs_n = 1'b0;
                sram_oe_n = 1'b0;
            end
            ST_WR_PULSE: begin
                sram_cs_n  = 1'b0;
                sram_we_n  = 1'b0;
                sram_dq_oe = 1'b1;
            end
            ST_WR_RECOVER: begin
                sram_cs_n  = 1'b0;
                sram_dq_oe = 1'b1;
            end
            default: ;
        endcase
    end

    sram_wait_timer #(.CNT_W(CNT_W)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (tmr_load),
        .load_val (tmr_val),
        .zero     (tmr_zero)
    );

    sram_io_latch #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_latch (
        .clk       (clk),
        .rst_n     (rst_n),
        .take_req  (accept),
        .req_addr  (req_addr),
        .req_wdata (req_wdata),
        .take_rd   (rd_take),
        .dq_i      (sram_dq_i),
        .addr_q    (sram_addr),
        .wdata_q   (sram_dq_o),
        .rdata_q   (rd_data)
    );

    assign ready = (state_q == ST_IDLE);
    assign done  = done_q;
endmodule

// File: rtl/async_sram_ctrl_checker.sv
`timescale 1ns/1ps
module async_sram_ctrl_checker #(
    parameter int ADDR_W = 15,
    parameter int AA_CYC = 3,
    parameter int WP_CYC = 3,
    parameter int HZ_CYC = 2
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req,
    input logic              ready,
    input logic              done,
    input logic [ADDR_W-1:0] sram_addr,
    input logic              sram_cs_n,
    input logic              sram_we_n,
    input logic              sram_oe_n,
    input logic              sram_dq_oe
);
    logic [7:0] we_lo_run;
    logic [7:0] oe_lo_run;
    logic [7:0] oe_hi_run;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            we_lo_run <= '0;
            oe_lo_run <= '0;
            oe_hi_run <= 8'hFF;
        end else begin
            we_lo_run <= !sram_we_n ? ((we_lo_run == 8'hFF) ? we_lo_run : we_lo_run + 1'b1) : 8'h00;
            oe_lo_run <= !sram_oe_n ? ((oe_lo_run == 8'hFF) ? oe_lo_run : oe_lo_run + 1'b1) : 8'h00;
            oe_hi_run <=  sram_oe_n ? ((oe_hi_run == 8'hFF) ? oe_hi_run : oe_hi_run + 1'b1) : 8'h00;
        end
    end

    assert_busy_after_accept_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (req && ready) |=> !ready);

    assert_addr_held_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!sram_cs_n && $past(!sram_cs_n)) |-> $stable(sram_addr));

    assert_read_length_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sram_oe_n) |-> (oe_lo_run == 8'(AA_CYC)));

    assert_pulse_length_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sram_we_n) |-> (we_lo_run == 8'(WP_CYC)));

    assert_no_contention_R5: assert property (@(posedge clk) disable iff (!rst_n)
        sram_dq_oe |-> sram_oe_n);

    assert_float_before_drive_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sram_dq_oe) |-> (oe_hi_run >= 8'(HZ_CYC)));

    assert_done_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    assert_deselect_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
        sram_cs_n |-> (sram_we_n && sram_oe_n));

    assert_no_we_with_oe_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !sram_we_n |-> sram_oe_n);
endmodule

bind async_sram_ctrl async_sram_ctrl_checker #(
    .ADDR_W (ADDR_W),
    .AA_CYC (AA_CYC),
    .WP_CYC (WP_CYC),
    .HZ_CYC (HZ_CYC)
) u_checker (
    .clk        (clk),
    .rst_n      (rst_n),
    .req        (req),
    .ready      (ready),
    .done       (done),
    .sram_addr  (sram_addr),
    .sram_cs_n  (sram_cs_n),
    .sram_we_n  (sram_we_n),
    .sram_oe_n  (sram_oe_n),
    .sram_dq_oe (sram_dq_oe)
);

// File: tb/async_sram_ctrl_bench.sv
`timescale 1ns/1ps
module async_sram_ctrl_bench;
    localparam int  PER     = 4;
    localparam real T_AA    = 12.0;
    localparam real T_OHZ   = 6.0;
    localparam real T_WP    = 10.0;
    localparam real T_DW    = 7.0;
    localparam real T_AW    = 10.0;
    localparam int  AA_CYC  = (12 + PER - 1) / PER;
    localparam int  HZ_CYC  = (6 + PER - 1) / PER;
    localparam int  WP_CYC  = (10 + PER - 1) / PER;
    localparam int  REC_CYC = 1;

    logic clk = 1'b0;
    always #2 clk = ~clk;

    logic        rst_n, req, req_wr, ready, done;
    logic [14:0] req_addr, sram_addr;
    logic [7:0]  req_wdata, rd_data, sram_dq_o, sram_dq_i, model_out;
    logic        sram_cs_n, sram_we_n, sram_oe_n, sram_dq_oe;

    async_sram_ctrl u_async_sram_ctrl (
        .clk(clk), .rst_n(rst_n), .req(req), .req_wr(req_wr),
        .req_addr(req_addr), .req_wdata(req_wdata), .ready(ready),
        .rd_data(rd_data), .done(done), .sram_addr(sram_addr),
        .sram_cs_n(sram_cs_n), .sram_we_n(sram_we_n), .sram_oe_n(sram_oe_n),
        .sram_dq_o(sram_dq_o), .sram_dq_oe(sram_dq_oe), .sram_dq_i(sram_dq_i)
    );

    int n_checks = 0;
    int n_err    = 0;

    task automatic check(input bit ok, input string rq, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", rq, act, exp, $time);
        end
    endtask

    function automatic logic [7:0] fill(input int a);
        return 8'((a * 7) ^ (a >> 8));
    endfunction

    // Behavioural memory with nanosecond timing
    logic [7:0] mem  [0:32767];
    logic [7:0] refm [0:32767];
    real rd_chg = -100.0, float_until = -100.0, we_fall = 0.0, dq_chg = 0.0, a_chg = 0.0;
    logic rd_ok = 1'b0;
    int   setup_bad = 0;

    initial begin
        for (int a = 0; a < 32768; a++) begin
            mem[a]  = fill(a);
            refm[a] = fill(a);
        end
    end

    always @(sram_addr or sram_oe_n or sram_cs_n) rd_chg = $realtime;
    initial begin
        #0.25;
        forever begin
            rd_ok = (($realtime - rd_chg) >= (T_AA - 0.5));
            #0.5;
        end
    end
    always @(posedge sram_oe_n) float_until = $realtime + T_OHZ;

    // Before the access time has elapsed the model returns a corrupted byte
    assign model_out = (!sram_cs_n && !sram_oe_n && sram_we_n)
                       ? (rd_ok ? mem[sram_addr] : ~mem[sram_addr]) : 8'h00;
    assign sram_dq_i = sram_dq_oe ? sram_dq_o : model_out;

    always @(sram_dq_i) dq_chg = $realtime;
    always @(sram_addr) a_chg  = $realtime;
    always @(negedge sram_we_n) if (rst_n === 1'b1 && sram_cs_n === 1'b0) we_fall = $realtime;
    always @(posedge sram_we_n) begin
        if (rst_n === 1'b1 && sram_cs_n === 1'b0) begin
            if (($realtime - we_fall) < T_WP) setup_bad++;
            if (($realtime - dq_chg)  < T_DW) setup_bad++;
            if (($realtime - a_chg)   < T_AW) setup_bad++;
            mem[sram_addr] = sram_dq_i;
        end
    end

    // Per-cycle port monitor
    int we_run = 0, oe_run = 0, cs_run = 0;
    int r9_bad = 0, r5_bad = 0, r7_bad = 0, r6_bad = 0;
    logic [14:0] cs_addr;
    logic [7:0]  cs_data;
    always @(negedge clk) begin
        if (rst_n) begin
            if (sram_cs_n && (!sram_we_n || !sram_oe_n)) r9_bad++;
            if (!sram_we_n && !sram_oe_n) r9_bad++;
            if (sram_dq_oe && !sram_oe_n) r5_bad++;
            if (sram_dq_oe && ($realtime <= float_until)) r7_bad++;
            if (sram_dq_oe && sram_oe_n && sram_cs_n) r5_bad++;
            if (!sram_we_n) we_run++;
            else if (we_run != 0) begin
                check(we_run == WP_CYC, "R4 write pulse cycles", we_run, WP_CYC);
                we_run = 0;
            end
            if (!sram_oe_n) oe_run++;
            else if (oe_run != 0) begin
                check(oe_run == AA_CYC, "R3 read enable cycles", oe_run, AA_CYC);
                oe_run = 0;
            end
            if (!sram_cs_n) begin
                if (cs_run != 0 && (sram_addr != cs_addr || (sram_dq_oe && sram_dq_o != cs_data))) r6_bad++;
                cs_run++;
                cs_addr = sram_addr;
                cs_data = sram_dq_o;
            end else cs_run = 0;
        end
    end

    task automatic do_op(input bit wr, input logic [14:0] a, input logic [7:0] d,
                         output logic [7:0] rd);
        int n;
        @(negedge clk);
        while (!ready) @(negedge clk);
        req = 1'b1; req_wr = wr; req_addr = a; req_wdata = d;
        @(negedge clk);
        req = 1'b0;
        n = 1;
        check(!ready, "R2 ready low after accept", ready, 0);
        while (!done && n < 40) begin
            @(negedge clk);
            n++;
        end
        rd = rd_data;
        check(n == (wr ? WP_CYC + REC_CYC + 1 : AA_CYC + 1), "R8 done latency", n,
              wr ? WP_CYC + REC_CYC + 1 : AA_CYC + 1);
        n = 0;
        @(negedge clk);
        check(!done, "R8 done single cycle", done, 0);
        while (!ready && n < 40) begin
            n++;
            @(negedge clk);
        end
        check(n == (wr ? 0 : HZ_CYC - 1), "R7 float wait before ready", n, wr ? 0 : HZ_CYC - 1);
        if (wr) refm[a] = d;
    endtask

    initial begin
        #(200000 * PER);
        check(1'b0, "watchdog", 0, 1);
        $display("Result: errors=%0d of %0d checks", n_err, n_checks);
        $finish;
    end

    initial begin
        logic [7:0]  got, held;
        logic [15:0] lfsr;
        rst_n = 1'b0; req = 1'b0; req_wr = 1'b0; req_addr = '0; req_wdata = '0;
        repeat (3) @(negedge clk);
        check(sram_cs_n && sram_we_n && sram_oe_n, "R1 controls high in reset",
              {sram_cs_n, sram_we_n, sram_oe_n}, 7);
        check(!sram_dq_oe && !done && ready, "R1 driver off, idle in reset",
              {sram_dq_oe, done, ready}, 1);
        rst_n = 1'b1;
        @(negedge clk);
        check(sram_cs_n && sram_we_n && sram_oe_n && !sram_dq_oe, "R1 state after reset",
              {sram_cs_n, sram_we_n, sram_oe_n, sram_dq_oe}, 14);

        // Read of untouched content
        do_op(1'b0, 15'h1234, 8'h00, got);
        check(got == fill(15'h1234), "R10 initial content read", got, fill(15'h1234));

        // Address sweep: writes, then reads back
        for (int i = 0; i < 256; i++) begin
            do_op(1'b1, 15'(i * 129 + 7), 8'(i * 37 + 5), got);
        end
        for (int i = 0; i < 256; i++) begin
            do_op(1'b0, 15'(i * 129 + 7), 8'h00, got);
            check(got == 8'(i * 37 + 5), "R10 sweep read-back", got, 8'(i * 37 + 5));
        end

        // Read data held across a write
        do_op(1'b0, 15'h0007, 8'h00, held);
        do_op(1'b1, 15'h7FFF, 8'hC3, got);
        check(rd_data == held, "R8 rd_data kept through write", rd_data, held);
        do_op(1'b0, 15'h7FFF, 8'h00, got);
        check(got == 8'hC3, "R10 top address", got, 8'hC3);

        // Request raised while busy must be ignored
        @(negedge clk);
        while (!ready) @(negedge clk);
        req = 1'b1; req_wr = 1'b1; req_addr = 15'h0123; req_wdata = 8'h5A;
        @(negedge clk);
        req_addr = 15'h0456; req_wdata = 8'hA5;
        check(!ready, "R2 busy during write", ready, 0);
        @(negedge clk);
        check(!ready, "R2 busy while request held", ready, 0);
        req = 1'b0;
        while (!ready) @(negedge clk);
        refm[15'h0123] = 8'h5A;
        do_op(1'b0, 15'h0456, 8'h00, got);
        check(got == fill(15'h0456), "R2 busy request ignored", got, fill(15'h0456));
        do_op(1'b0, 15'h0123, 8'h00, got);
        check(got == 8'h5A, "R10 accepted write landed", got, 8'h5A);

        // Mixed reads and writes on a small window: many read-to-write turnarounds
        lfsr = 16'hACE1;
        for (int i = 0; i < 600; i++) begin
            logic [14:0] a;
            a = 15'h4000 | 15'(lfsr[5:0]);
            if (lfsr[9]) begin
                do_op(1'b1, a, lfsr[15:8] ^ 8'(i), got);
            end else begin
                do_op(1'b0, a, 8'h00, got);
                check(got == refm[a], "R10 mixed read", got, refm[a]);
            end
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
        end

        check(r9_bad == 0, "R9 control encoding", r9_bad, 0);
        check(r5_bad == 0, "R5 driver only in write", r5_bad, 0);
        check(r7_bad == 0, "R7 driver after float time", r7_bad, 0);
        check(r6_bad == 0, "R6 address and data held while selected", r6_bad, 0);
        check(setup_bad == 0, "R4 pulse width and setup times", setup_bad, 0);

        $display("Result: errors=%0d of %0d checks", n_err, n_checks);
        $finish;
    end
endmodule